// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt requests from a 32-bit primary level and a 32-bit secondary level and turns them into one CPU interrupt request plus a source number. Three positions of the primary level carry no raw line. Each one summarises an uneven range of the secondary level, so secondary requests are gated twice: once by the secondary mask and once by the primary mask of their summary bit.

Each source bit has a fixed behaviour. Some bits are level bits that track their synchronized input. Others are edge bits that latch a rising transition and hold it until software clears it. Edge latches are cleared by writing a zero to the bit; a one leaves it alone. Three primary bits can also be raised by software through a dedicated register.

A combinational vector output gives the lowest-numbered pending masked primary source. When that source is a summary bit, the vector is 32 plus the lowest pending masked secondary source. A valid flag goes with the vector.

Top module: `cic_top`

## Requirements
- R1: A synchronous active-high reset clears the primary mask (address 1), the primary edge latches (address 2), the soft register (address 3), the secondary edge latches and the secondary mask (address 5); `cpu_irq` and `vec_valid` are then low.
- R2: Primary bits 0–3, 7–15, 20–21 and 25–27 are level bits. The primary status (address 0, read-only) shows the input after a two-flop synchronizer and drops again when the input falls.
- R3: Primary bits 16–19, 22–24 and 28–31 latch a rising input edge and stay set after the input falls. Writing address 2 with a bit at 0 clears that latch; writing 1 leaves it set. Address 2 reads back the latches.
- R4: Bits 28–30 of the soft register (address 3) read back and appear in primary status. All other bits of that register always read 0.
- R5: Secondary bits 16, 22 and 28 latch a rising edge and are cleared by writing the secondary status (address 4) with that bit at 0. All other secondary bits are level bits.
- R6: Primary bit 4 is the OR of masked secondary bits 16–31, bit 5 of bits 8–15, and bit 6 of bits 0–7. The raw primary inputs at positions 4–6 have no effect.
- R7: `cpu_irq` is high exactly when primary status AND primary mask is nonzero.
- R8: `vec_idx` is the index of the lowest set bit of the masked primary status. When that bit is 4, 5 or 6, `vec_idx` is 32 plus the index of the lowest set bit of the masked secondary status.
- R9: `vec_valid` is low whenever no masked primary bit is pending.
- R10: If an edge arrives on a latched bit in the same cycle as a write that clears it, the latch stays set.
- R11: Reads of unmapped addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_raw | input | 32 | Raw primary request lines (positions 4–6 unused) |
| sec_raw | input | 32 | Raw secondary request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_irq | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | Vector output is meaningful |
| vec_idx | output | 6 | Pending source number, 0–63 |

## Verification
The bench walks a single active line across every primary position and then across every secondary position. For each one it checks the status, the IRQ and the vector, which shows that each bit lands in the right place and that the three uneven groups map to the right summary bit. For every bit, dropping the input tells the level bits from the edge bits. The clear writes then show that a zero clears a latch and a one does not. Paired sources check the ordering between two primary bits and between a primary bit and a summary-routed secondary bit. Other cases check masking at both levels, the ignored inputs at the summary positions, the soft register and the timed clear-versus-edge collision.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int PW = 32;
    localparam int SW = 32;
    localparam int IW = $clog2(PW);
    localparam int VW = IW + 1;
    localparam int NGRP = 3;

    typedef enum logic [2:0] {
        A_PSTAT = 3'd0,
        A_PMASK = 3'd1,
        A_HARD  = 3'd2,
        A_SOFT  = 3'd3,
        A_SSTAT = 3'd4,
        A_SMASK = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic          valid;
        logic [VW-1:0] idx;
    } vec_t;

    localparam logic [PW-1:0] DEF_PRI_EDGE = 32'hF1CF_0000;
    localparam logic [SW-1:0] DEF_SEC_EDGE = 32'h1041_0000;
    localparam logic [PW-1:0] DEF_SOFT     = 32'h7000_0000;

    function automatic logic [IW-1:0] lowest_set(input logic [PW-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = PW - 1; i >= 0; i--) begin
            if (v[i]) r = IW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/cic_srcbank.sv
module cic_srcbank #(
    parameter int           W         = 32,
    parameter logic [W-1:0] EDGE_BITS = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise,
    input  logic         clr_en,
    input  logic [W-1:0] keep,
    output logic [W-1:0] status,
    output logic [W-1:0] latched
);
    logic [W-1:0] lat_q, held;

    always_comb begin
        held = clr_en ? (lat_q & keep) : lat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= held | (rise & EDGE_BITS);
    end

    assign latched = lat_q;
    assign status  = (lvl & ~EDGE_BITS) | lat_q;
endmodule

// File: rtl/cic_top.sv
module cic_top
    import cic_pkg::*;
#(
    parameter logic [PW-1:0] PRI_EDGE  = DEF_PRI_EDGE,
    parameter logic [SW-1:0] SEC_EDGE  = DEF_SEC_EDGE,
    parameter logic [PW-1:0] SOFT_BITS = DEF_SOFT,
    parameter int unsigned   SUM_POS [NGRP] = '{4, 5, 6},
    parameter logic [SW-1:0] SUM_GRP [NGRP] = '{32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pri_raw,
    input  logic [SW-1:0] sec_raw,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          cpu_irq,
    output logic          vec_valid,
    output logic [VW-1:0] vec_idx
);
    logic [PW-1:0] sum_pos_mask;
    always_comb begin
        sum_pos_mask = '0;
        for (int g = 0; g < NGRP; g++) sum_pos_mask[SUM_POS[g]] = 1'b1;
    end

    logic [PW-1:0] p_lvl, p_rise, p_stat_src, p_lat;
    logic [SW-1:0] s_lvl, s_rise, s_stat, s_lat;
    logic [PW-1:0] pmask_q, soft_q, pstat, pmasked;
    logic [SW-1:0] smask_q, smasked;
    logic [NGRP-1:0] sum_bits;

    cic_sync #(.W(PW)) u_psync (
        .clk(clk), .rst(rst), .raw(pri_raw & ~sum_pos_mask),
        .lvl(p_lvl), .rise(p_rise)
    );
    cic_sync #(.W(SW)) u_ssync (
        .clk(clk), .rst(rst), .raw(sec_raw),
        .lvl(s_lvl), .rise(s_rise)
    );

    logic wr_hard, wr_sstat;
    assign wr_hard  = reg_we && (reg_addr == A_HARD);
    assign wr_sstat = reg_we && (reg_addr == A_SSTAT);

    cic_srcbank #(.W(PW), .EDGE_BITS(PRI_EDGE)) u_pbank (
        .clk(clk), .rst(rst), .lvl(p_lvl), .rise(p_rise),
        .clr_en(wr_hard), .keep(reg_wdata[PW-1:0]),
        .status(p_stat_src), .latched(p_lat)
    );
    cic_srcbank #(.W(SW), .EDGE_BITS(SEC_EDGE)) u_sbank (
        .clk(clk), .rst(rst), .lvl(s_lvl), .rise(s_rise),
        .clr_en(wr_sstat), .keep(reg_wdata[SW-1:0]),
        .status(s_stat), .latched(s_lat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask_q <= '0;
            smask_q <= '0;
            soft_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_PMASK: pmask_q <= reg_wdata[PW-1:0];
                A_SMASK: smask_q <= reg_wdata[SW-1:0];
                A_SOFT:  soft_q  <= reg_wdata[PW-1:0] & SOFT_BITS;
                default: ;
            endcase
        end
    end

    assign smasked = s_stat & smask_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_sum
        assign sum_bits[g] = |(smasked & SUM_GRP[g]);
    end

    always_comb begin
        pstat = (p_stat_src & ~sum_pos_mask) | soft_q;
        for (int g = 0; g < NGRP; g++) pstat[SUM_POS[g]] = sum_bits[g];
    end

    assign pmasked = pstat & pmask_q;

    vec_t          vec;
    logic [IW-1:0] p_low, s_low;
    always_comb begin
        p_low     = lowest_set(pmasked);
        s_low     = lowest_set(smasked);
        vec.valid = |pmasked;
        if (sum_pos_mask[p_low]) vec.idx = {1'b1, s_low};
        else                     vec.idx = {1'b0, p_low};
    end

    assign cpu_irq   = vec.valid;
    assign vec_valid = vec.valid;
    assign vec_idx   = vec.idx;

    always_comb begin
        case (reg_addr)
            A_PSTAT: reg_rdata = pstat;
            A_PMASK: reg_rdata = pmask_q;
            A_HARD:  reg_rdata = p_lat;
            A_SOFT:  reg_rdata = soft_q;
            A_SSTAT: reg_rdata = s_stat;
            A_SMASK: reg_rdata = smask_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cic_top_chk.sv
module cic_top_chk
    import cic_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [PW-1:0] p_lat,
    input logic [PW-1:0] pmasked,
    input logic [SW-1:0] smasked,
    input logic [PW-1:0] pmask_q,
    input logic [SW-1:0] smask_q,
    input logic [PW-1:0] soft_q,
    input logic          cpu_irq,
    input logic          vec_valid,
    input logic [VW-1:0] vec_idx
);
    // R1: one cycle after reset, the masks and soft register are clear
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (pmask_q == '0 && smask_q == '0 && soft_q == '0));

    // R3: a primary edge latch only drops when the latch register is written
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == A_HARD) |=> ((p_lat & $past(p_lat)) == $past(p_lat)));

    // R9: no valid vector without a CPU request
    p_valid_needs_irq_r9: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq |-> !vec_valid);

    // R8: a primary vector points at a pending masked primary bit, none lower
    p_pri_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_idx[VW-1]) |->
            (pmasked[vec_idx[IW-1:0]] &&
             ((pmasked & ((32'd1 << vec_idx[IW-1:0]) - 32'd1)) == '0)));

    // R8: a secondary vector points at the lowest pending masked secondary bit
    p_sec_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_idx[VW-1]) |->
            (smasked[vec_idx[IW-1:0]] &&
             ((smasked & ((32'd1 << vec_idx[IW-1:0]) - 32'd1)) == '0)));
endmodule

bind cic_top cic_top_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .p_lat(p_lat), .pmasked(pmasked), .smasked(smasked),
    .pmask_q(pmask_q), .smask_q(smask_q), .soft_q(soft_q),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_idx(vec_idx)
);

// File: tb/cic_top_tb.sv
module cic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pri_raw = '0, sec_raw = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq, vec_valid;
    logic [5:0]  vec_idx;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] PEDGE = 32'hF1CF_0000;
    localparam logic [31:0] SEDGE = 32'h1041_0000;

    always #10 clk = ~clk;

    cic_top dut_i (
        .clk(clk), .rst(rst), .pri_raw(pri_raw), .sec_raw(sec_raw),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .vec_valid(vec_valid),
        .vec_idx(vec_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int grp_of(input int s);
        if (s >= 16) return 4;
        if (s >= 8)  return 5;
        return 6;
    endfunction

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        rd(3'd1, d); chk("R1 pmask", d, 0);
        rd(3'd2, d); chk("R1 hard", d, 0);
        rd(3'd3, d); chk("R1 soft", d, 0);
        rd(3'd5, d); chk("R1 smask", d, 0);
        rd(3'd4, d); chk("R1 sstat", d, 0);
        chk("R1 irq", {30'd0, cpu_irq, vec_valid}, 0);
        // R11 unmapped
        rd(3'd6, d); chk("R11 addr6", d, 0);
        rd(3'd7, d); chk("R11 addr7", d, 0);

        wr(3'd1, 32'hFFFF_FFFF);
        // R2/R3/R7/R8 primary sweep
        for (int b = 0; b < 32; b++) begin
            if (b >= 4 && b <= 6) continue;
            pri_raw = 32'd1 << b;
            step(4);
            rd(3'd0, d); chk($sformatf("R2 pstat set bit%0d", b), d, 32'd1 << b);
            chk($sformatf("R7 irq bit%0d", b), {31'd0, cpu_irq}, 1);
            chk($sformatf("R8 vec bit%0d", b), {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'(b)});
            pri_raw = '0;
            step(4);
            rd(3'd0, d);
            if (PEDGE[b]) begin
                chk($sformatf("R3 held bit%0d", b), d, 32'd1 << b);
                wr(3'd2, 32'hFFFF_FFFF);
                rd(3'd0, d); chk($sformatf("R3 ones keep bit%0d", b), d, 32'd1 << b);
                wr(3'd2, ~(32'd1 << b));
                rd(3'd0, d); chk($sformatf("R3 cleared bit%0d", b), d, 0);
            end else begin
                chk($sformatf("R2 dropped bit%0d", b), d, 0);
            end
        end

        // R6 raw inputs at summary positions ignored
        pri_raw = 32'h0000_0070;
        step(4);
        rd(3'd0, d); chk("R6 raw summary ignored", d, 0);
        chk("R6 no irq", {31'd0, cpu_irq}, 0);
        pri_raw = '0;

        // R5/R6/R8 secondary sweep
        wr(3'd5, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            sec_raw = 32'd1 << s;
            step(4);
            rd(3'd4, d); chk($sformatf("R5 sstat bit%0d", s), d, 32'd1 << s);
            rd(3'd0, d); chk($sformatf("R6 summary for sec%0d", s), d, 32'd1 << grp_of(s));
            chk($sformatf("R8 sec vec %0d", s), {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'(32 + s)});
            sec_raw = '0;
            step(4);
            rd(3'd4, d);
            if (SEDGE[s]) begin
                chk($sformatf("R5 held sec%0d", s), d, 32'd1 << s);
                wr(3'd4, 32'hFFFF_FFFF);
                rd(3'd4, d); chk($sformatf("R5 ones keep sec%0d", s), d, 32'd1 << s);
                wr(3'd4, ~(32'd1 << s));
                rd(3'd4, d); chk($sformatf("R5 cleared sec%0d", s), d, 0);
            end else begin
                chk($sformatf("R5 level drop sec%0d", s), d, 0);
            end
        end

        // R8 ordering between two primaries and primary vs secondary
        pri_raw = (32'd1 << 9) | (32'd1 << 20);
        step(4);
        chk("R8 two primaries", {26'd0, vec_idx}, 9);
        pri_raw = 32'd1 << 2; sec_raw = 32'd1 << 3;
        step(4);
        chk("R8 primary below summary", {26'd0, vec_idx}, 2);
        pri_raw = 32'd1 << 7; sec_raw = 32'd1 << 20;
        step(4);
        chk("R8 summary below primary", {26'd0, vec_idx}, 52);
        // R6 secondary mask gates summary
        wr(3'd5, 32'h0);
        pri_raw = '0;
        step(4);
        rd(3'd4, d); chk("R6 sstat unmasked view", d, 32'd1 << 20);
        rd(3'd0, d); chk("R6 masked summary low", d, 0);
        sec_raw = '0;
        wr(3'd5, 32'hFFFF_FFFF);
        // R7/R9 primary mask
        wr(3'd1, 32'h0);
        pri_raw = 32'd1;
        step(4);
        rd(3'd0, d); chk("R7 status visible while masked", d, 1);
        chk("R7 masked irq low", {31'd0, cpu_irq}, 0);
        chk("R9 valid low", {31'd0, vec_valid}, 0);
        pri_raw = '0;
        wr(3'd1, 32'hFFFF_FFFF);
        step(4);

        // R4 soft register
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R4 soft readback", d, 32'h7000_0000);
        wr(3'd3, 32'd1 << 29);
        rd(3'd0, d); chk("R4 soft in status", d, 32'd1 << 29);
        chk("R4 soft vec", {26'd0, vec_idx}, 29);
        wr(3'd3, 0);
        rd(3'd0, d); chk("R4 soft cleared", d, 0);

        // R10 edge wins over same-cycle clear (bit 16)
        @(negedge clk);
        pri_raw = 32'd1 << 16;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0;
        rd(3'd2, d); chk("R10 edge wins", d, 32'd1 << 16);
        pri_raw = '0;
        wr(3'd2, 0);
        rd(3'd2, d); chk("R3 plain clear", d, 0);

        // R1 reset again clears programmed state
        wr(3'd3, 32'd1 << 28);
        @(negedge clk); rst = 1'b1;
        step(2); rst = 1'b0;
        rd(3'd1, d); chk("R1 pmask after reset", d, 0);
        rd(3'd3, d); chk("R1 soft after reset", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule